// File: doc/BRIEF.md
# Periodic and One-Shot Comparator Channel

This block is a single timer channel inside a multi-channel event timer. It observes a shared free-running main counter and emits a one-clock fire strobe when the counter, while enabled, equals the channel's comparator. Interrupt gating and routing happen downstream. The channel runs in one of two modes. In one-shot mode the comparator holds whatever software wrote. In periodic mode a separate rate register advances the comparator after every match, so the channel keeps firing at a fixed interval.

Software programs the channel through a small write port. The port carries a configuration word and the low and high halves of the comparator, and each byte lane can be masked. In periodic mode a comparator write always sets the reload rate. It replaces the live comparator only when a value-set bit was armed beforehand, and that bit disarms itself after any comparator write. Leaving periodic mode zeroes the rate. The main counter, the bus decode and the interrupt router sit outside the block.

Top module: `tmr_cmp_channel`

## Requirements
- R1: While reset is asserted, the comparator reads 0xFFFFFFFF. The rate, the periodic, value-set and interrupt-enable bits, and the fire strobe all read 0.
- R2: `fire` is high for exactly the one clock that follows a rising edge at which `cnt_en`=1 and `cnt_val` equals the comparator. The interrupt-enable bit has no effect on it.
- R3: With `cnt_en`=0 no match occurs, and `fire` stays low on the following clock.
- R4: In periodic mode a match adds the rate to the comparator, modulo 2^32, on the same edge. The next match therefore lies ahead of the counter.
- R5: In periodic mode a low-half comparator write always merges the data into the rate. It loads the merged rate into the comparator only when the value-set bit was 1 at that edge.
- R6: Any comparator write, to either half and in either mode, clears the value-set bit.
- R7: A configuration write that leaves the periodic bit at 0 zeroes the rate. The rate stays 0 while the channel is in one-shot mode.
- R8: In one-shot mode a low-half comparator write loads the comparator directly and a match leaves it unchanged. A value behind the counter is not corrected and matches only after the counter wraps.
- R9: In a comparator write, `wr_strb[i]`=1 updates byte i (bits 8i+7..8i) and `wr_strb[i]`=0 keeps that byte.
- R10: A high-half comparator write stores no data. It leaves the comparator and the rate unchanged, apart from a periodic match advance on that same edge.
- R11: Address encoding: 0 is configuration, 1 is the comparator low half, 2 is the comparator high half, and 3 is ignored. In configuration data, bit 0 is periodic mode, bit 1 is value-set and bit 2 is interrupt enable. These bits update only when `wr_strb[0]`=1.
- R12: When a low-half comparator write and a periodic match fall on the same edge, the write decides the comparator. The fire strobe still follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cnt_val | input | CNT_W | Shared main counter value |
| cnt_en | input | 1 | Main counter running |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write target (R11 encoding) |
| wr_data | input | CNT_W | Write data |
| wr_strb | input | CNT_W/8 | Byte-lane enables |
| cmp_value | output | CNT_W | Live comparator |
| rate_value | output | CNT_W | Periodic reload rate |
| mode_periodic | output | 1 | Periodic mode selected |
| vset_armed | output | 1 | Value-set bit |
| irq_enable | output | 1 | Interrupt enable for the router |
| fire | output | 1 | One-clock match strobe |

## Verification
A corrupted comparator or rate shows at the ports within one clock, because both are brought out and compared against the reference every cycle. A wrong advance also moves the next fire strobe to a different counter value. A value-set bit that fails to self-clear appears on the next cycle and changes the result of the following periodic comparator write. A wrong match decision appears on `fire` one clock after the counter value that caused it.

// File: rtl/tmr_cmp_pkg.sv
package tmr_cmp_pkg;

  // Write-port targets
  typedef enum logic [1:0] {
    WA_CFG    = 2'd0,
    WA_CMP_LO = 2'd1,
    WA_CMP_HI = 2'd2,
    WA_NONE   = 2'd3
  } wr_addr_e;

  // Bit positions inside configuration write data
  localparam int unsigned CFG_PERIODIC_BIT = 0;
  localparam int unsigned CFG_VSET_BIT     = 1;
  localparam int unsigned CFG_IRQEN_BIT    = 2;
  localparam int unsigned CFG_BITS         = 3;

  typedef struct packed {
    logic irq_en;
    logic vset;
    logic periodic;
  } chan_cfg_t;

endpackage

// File: rtl/tmr_cmp_lane_merge.sv
module tmr_cmp_lane_merge #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0]   old_val,
  input  logic [DATA_W-1:0]   new_val,
  input  logic [DATA_W/8-1:0] strb,
  output logic [DATA_W-1:0]   merged
);
  localparam int unsigned LANES = DATA_W / 8;

  // R9: per-byte select between stored and written data
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[g*8 +: 8] = strb[g] ? new_val[g*8 +: 8] : old_val[g*8 +: 8];
  end
endmodule

// File: rtl/tmr_cmp_cfg.sv
module tmr_cmp_cfg
  import tmr_cmp_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic                cfg_lane0,
  input  logic [CFG_BITS-1:0] cfg_bits,
  input  logic                cmp_wr,
  output chan_cfg_t           cfg_q,
  output logic                rate_clr
);
  chan_cfg_t cfg_d;
  logic      cfg_ld;

  always_comb begin
    cfg_d  = cfg_q;
    cfg_ld = 1'b0;
    if (cfg_wr && cfg_lane0) begin
      cfg_d.periodic = cfg_bits[CFG_PERIODIC_BIT];
      cfg_d.vset     = cfg_bits[CFG_VSET_BIT];
      cfg_d.irq_en   = cfg_bits[CFG_IRQEN_BIT];
      cfg_ld         = 1'b1;
    end else if (cmp_wr) begin
      cfg_d.vset = 1'b0;          // R6 self-clear
      cfg_ld     = 1'b1;
    end
  end

  // R7: a configuration write that ends in one-shot zeroes the rate
  assign rate_clr = cfg_wr && cfg_lane0 && !cfg_bits[CFG_PERIODIC_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_ld) cfg_q <= cfg_d;
  end
endmodule

// File: rtl/tmr_cmp_rate.sv
module tmr_cmp_rate #(
  parameter int unsigned CNT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lo_wr,
  input  logic               periodic,
  input  logic               rate_clr,
  input  logic [CNT_W-1:0]   wr_data,
  input  logic [CNT_W/8-1:0] wr_strb,
  output logic [CNT_W-1:0]   rate_q,
  output logic [CNT_W-1:0]   rate_merged
);
  logic [CNT_W-1:0] rate_d;
  logic             rate_ld;

  tmr_cmp_lane_merge #(.DATA_W(CNT_W)) u_merge (
    .old_val (rate_q),
    .new_val (wr_data),
    .strb    (wr_strb),
    .merged  (rate_merged)
  );

  always_comb begin
    rate_d  = rate_q;
    rate_ld = 1'b0;
    if (rate_clr) begin
      rate_d  = '0;
      rate_ld = 1'b1;
    end else if (lo_wr && periodic) begin
      rate_d  = rate_merged;      // R5 rate always taken
      rate_ld = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rate_q <= '0;
    else if (rate_ld) rate_q <= rate_d;
  end
endmodule

// File: rtl/tmr_cmp_cmpreg.sv
module tmr_cmp_cmpreg #(
  parameter int unsigned CNT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lo_wr,
  input  logic               periodic,
  input  logic               vset,
  input  logic               hit,
  input  logic [CNT_W-1:0]   rate_q,
  input  logic [CNT_W-1:0]   rate_merged,
  input  logic [CNT_W-1:0]   wr_data,
  input  logic [CNT_W/8-1:0] wr_strb,
  output logic [CNT_W-1:0]   cmp_q
);
  logic [CNT_W-1:0] cmp_d;
  logic [CNT_W-1:0] cmp_merged;
  logic             cmp_ld;

  tmr_cmp_lane_merge #(.DATA_W(CNT_W)) u_merge (
    .old_val (cmp_q),
    .new_val (wr_data),
    .strb    (wr_strb),
    .merged  (cmp_merged)
  );

  always_comb begin
    cmp_d  = cmp_q;
    cmp_ld = 1'b0;
    if (lo_wr) begin              // R12 write wins over advance
      if (!periodic) begin
        cmp_d  = cmp_merged;      // R8 direct load
        cmp_ld = 1'b1;
      end else if (vset) begin
        cmp_d  = rate_merged;     // R5 armed load
        cmp_ld = 1'b1;
      end
    end else if (hit && periodic) begin
      cmp_d  = cmp_q + rate_q;    // R4 advance
      cmp_ld = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_q <= '1;
    else if (cmp_ld) cmp_q <= cmp_d;
  end
endmodule

// File: rtl/tmr_cmp_match.sv
module tmr_cmp_match #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] cmp_q,
  output logic             hit,
  output logic             fire_q
);
  assign hit = cnt_en && (cnt_val == cmp_q);   // R3 gated by enable

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fire_q <= 1'b0;
    else        fire_q <= hit;
  end
endmodule

// File: rtl/tmr_cmp_channel.sv
module tmr_cmp_channel
  import tmr_cmp_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   cnt_val,
  input  logic               cnt_en,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [CNT_W-1:0]   wr_data,
  input  logic [CNT_W/8-1:0] wr_strb,
  output logic [CNT_W-1:0]   cmp_value,
  output logic [CNT_W-1:0]   rate_value,
  output logic               mode_periodic,
  output logic               vset_armed,
  output logic               irq_enable,
  output logic               fire
);
  wr_addr_e         addr;
  logic             cfg_wr, lo_wr, hi_wr, cmp_wr;
  chan_cfg_t        cfg_q;
  logic             rate_clr;
  logic [CNT_W-1:0] rate_q, rate_merged, cmp_q;
  logic             hit;

  assign addr   = wr_addr_e'(wr_addr);
  assign cfg_wr = wr_en && (addr == WA_CFG);
  assign lo_wr  = wr_en && (addr == WA_CMP_LO);
  assign hi_wr  = wr_en && (addr == WA_CMP_HI);   // R10 data not stored
  assign cmp_wr = lo_wr || hi_wr;

  tmr_cmp_cfg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_lane0 (wr_strb[0]),
    .cfg_bits  (wr_data[CFG_BITS-1:0]),
    .cmp_wr    (cmp_wr),
    .cfg_q     (cfg_q),
    .rate_clr  (rate_clr)
  );

  tmr_cmp_rate #(.CNT_W(CNT_W)) u_rate (
    .clk         (clk),
    .rst_n       (rst_n),
    .lo_wr       (lo_wr),
    .periodic    (cfg_q.periodic),
    .rate_clr    (rate_clr),
    .wr_data     (wr_data),
    .wr_strb     (wr_strb),
    .rate_q      (rate_q),
    .rate_merged (rate_merged)
  );

  tmr_cmp_cmpreg #(.CNT_W(CNT_W)) u_cmp (
    .clk         (clk),
    .rst_n       (rst_n),
    .lo_wr       (lo_wr),
    .periodic    (cfg_q.periodic),
    .vset        (cfg_q.vset),
    .hit         (hit),
    .rate_q      (rate_q),
    .rate_merged (rate_merged),
    .wr_data     (wr_data),
    .wr_strb     (wr_strb),
    .cmp_q       (cmp_q)
  );

  tmr_cmp_match #(.CNT_W(CNT_W)) u_match (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_val (cnt_val),
    .cnt_en  (cnt_en),
    .cmp_q   (cmp_q),
    .hit     (hit),
    .fire_q  (fire)
  );

  assign cmp_value     = cmp_q;
  assign rate_value    = rate_q;
  assign mode_periodic = cfg_q.periodic;
  assign vset_armed    = cfg_q.vset;
  assign irq_enable    = cfg_q.irq_en;
endmodule

// File: rtl/tmr_cmp_channel_chk.sv
module tmr_cmp_channel_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_val,
  input logic             cnt_en,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [CNT_W-1:0] cmp_value,
  input logic [CNT_W-1:0] rate_value,
  input logic             mode_periodic,
  input logic             vset_armed,
  input logic             fire
);
  logic seen_hit, lo_w, any_cmp_w;
  assign seen_hit  = cnt_en && (cnt_val == cmp_value);
  assign lo_w      = wr_en && (wr_addr == 2'd1);
  assign any_cmp_w = wr_en && ((wr_addr == 2'd1) || (wr_addr == 2'd2));

  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |-> (cmp_value == {CNT_W{1'b1}} && rate_value == '0 && !fire));

  a_r2_fire_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    seen_hit |=> fire);

  a_r2_no_spurious_fire: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_hit |=> !fire);

  a_r3_quiet_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> !fire);

  a_r4_periodic_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_hit && mode_periodic && !lo_w) |=>
      cmp_value == CNT_W'($past(cmp_value) + $past(rate_value)));

  a_r6_vset_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    any_cmp_w |=> !vset_armed);

  a_r7_rate_zero_oneshot: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_periodic |-> rate_value == '0);

  a_r8_oneshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_periodic && !lo_w) |=> $stable(cmp_value));

  a_r10_high_half_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd2 && !(seen_hit && mode_periodic)) |=>
      ($stable(cmp_value) && $stable(rate_value)));
endmodule

bind tmr_cmp_channel tmr_cmp_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cnt_val       (cnt_val),
  .cnt_en        (cnt_en),
  .wr_en         (wr_en),
  .wr_addr       (wr_addr),
  .cmp_value     (cmp_value),
  .rate_value    (rate_value),
  .mode_periodic (mode_periodic),
  .vset_armed    (vset_armed),
  .fire          (fire)
);

// File: tb/test_tmr_cmp_channel.sv
`timescale 1ns/1ps
module test_tmr_cmp_channel;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] cnt_val;
  logic        cnt_en;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic [3:0]  wr_strb;
  logic [31:0] cmp_value, rate_value;
  logic        mode_periodic, vset_armed, irq_enable, fire;

  int total = 0;
  int failed = 0;
  bit armed = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tmr_cmp_channel i_tmr_cmp_channel (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_en(cnt_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
    .cmp_value(cmp_value), .rate_value(rate_value), .mode_periodic(mode_periodic),
    .vset_armed(vset_armed), .irq_enable(irq_enable), .fire(fire)
  );

  task automatic chk32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model state
  logic [31:0] m_cmp, m_rate;
  logic        m_per, m_vset, m_irq, m_fire;
  logic        m_hit, m_oper, m_ovset;

  function automatic logic [31:0] bytes_merge(input logic [31:0] o, input logic [31:0] n,
                                              input logic [3:0] s);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (s[b]) r[b*8 +: 8] = n[b*8 +: 8];
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cmp = 32'hFFFF_FFFF; m_rate = 0; m_per = 0; m_vset = 0; m_irq = 0; m_fire = 0;
    end else begin
      m_hit = cnt_en && (cnt_val == m_cmp);
      m_oper = m_per; m_ovset = m_vset;
      m_fire = m_hit;
      if (m_hit && m_oper && !(wr_en && wr_addr == 2'd1)) m_cmp = m_cmp + m_rate;
      if (wr_en) begin
        case (wr_addr)
          2'd0: if (wr_strb[0]) begin
                  m_per = wr_data[0]; m_vset = wr_data[1]; m_irq = wr_data[2];
                  if (!m_per) m_rate = 0;
                end
          2'd1: begin
                  if (m_oper) begin
                    m_rate = bytes_merge(m_rate, wr_data, wr_strb);
                    if (m_ovset) m_cmp = m_rate;
                  end else m_cmp = bytes_merge(m_cmp, wr_data, wr_strb);
                  m_vset = 0;
                end
          2'd2: m_vset = 0;
          default: ;
        endcase
      end
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && armed && !done) begin
      chk32("R2 fire vs model", {31'd0, fire}, {31'd0, m_fire});
      chk32("R4 comparator vs model", cmp_value, m_cmp);
      chk32("R7 rate vs model", rate_value, m_rate);
      chk32("R11 config vs model", {29'd0, irq_enable, vset_armed, mode_periodic},
            {29'd0, m_irq, m_vset, m_per});
    end
  end

  task automatic cyc();
    @(negedge clk);
    if (cnt_en) cnt_val = cnt_val + 1;
    wr_en = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] s);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_strb = s;
    cyc();
  endtask

  task automatic summary();
    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int nf;
    rst_n = 1'b1; cnt_val = 0; cnt_en = 0; wr_en = 0; wr_addr = 0; wr_data = 0; wr_strb = 0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk32("R1 reset comparator", cmp_value, 32'hFFFF_FFFF);
    chk32("R1 reset rate", rate_value, 0);
    chk32("R1 reset cfg/fire", {28'd0, fire, irq_enable, vset_armed, mode_periodic}, 0);
    rst_n = 1'b1; armed = 1;

    // One-shot match with interrupt enable set
    wr(2'd0, 32'h4, 4'h1);
    chk32("R11 irq enable bit", {31'd0, irq_enable}, 1);
    wr(2'd1, 32'h20, 4'hF);
    chk32("R8 one-shot direct load", cmp_value, 32'h20);
    cnt_val = 32'h1C; cnt_en = 1;
    while (cnt_val != 32'h21) cyc();
    chk32("R2 fire at match", {31'd0, fire}, 1);
    cyc();
    chk32("R2 single-cycle pulse", {31'd0, fire}, 0);
    chk32("R8 one-shot holds after match", cmp_value, 32'h20);

    // Interrupt enable cleared: still fires
    wr(2'd0, 32'h0, 4'h1);
    cnt_val = 32'h1E;
    while (cnt_val != 32'h21) cyc();
    chk32("R2 fires with irq disabled", {31'd0, fire}, 1);

    // Counter stopped on the comparator value
    cnt_en = 0; cnt_val = 32'h20;
    nf = 0;
    repeat (5) begin cyc(); nf += fire; end
    chk32("R3 no fire while stopped", nf, 0);

    // One-shot value behind the counter
    cnt_val = 32'h100; cnt_en = 1;
    wr(2'd1, 32'h50, 4'hF);
    nf = 0;
    repeat (20) begin cyc(); nf += fire; end
    chk32("R8 no fire before wrap", nf, 0);
    cnt_val = 32'hFFFF_FFFE;
    nf = 0;
    while (cnt_val != 32'h51) begin cyc(); nf += fire; end
    chk32("R8 fire after wrap", {31'd0, fire}, 1);
    chk32("R8 exactly one fire", nf, 1);
    cnt_en = 0;

    // Periodic with armed value-set
    wr(2'd0, 32'h3, 4'h1);
    chk32("R11 periodic+vset", {30'd0, vset_armed, mode_periodic}, 3);
    wr(2'd1, 32'h10, 4'hF);
    chk32("R5 rate loaded", rate_value, 32'h10);
    chk32("R5 armed comparator load", cmp_value, 32'h10);
    chk32("R6 vset cleared", {31'd0, vset_armed}, 0);
    cnt_val = 32'h0E; cnt_en = 1;
    nf = 0;
    while (cnt_val != 32'h36) begin cyc(); nf += fire; end
    chk32("R4 periodic fire count", nf, 3);
    chk32("R4 comparator advanced", cmp_value, 32'h40);
    cnt_en = 0;

    // Periodic write without value-set
    wr(2'd1, 32'h8, 4'hF);
    chk32("R5 rate without vset", rate_value, 32'h8);
    chk32("R5 comparator kept", cmp_value, 32'h40);

    // Byte-lane mask
    wr(2'd0, 32'h3, 4'h1);
    wr(2'd1, 32'hAABB_CCDD, 4'b0010);
    chk32("R9 masked rate", rate_value, 32'h0000_CC08);
    chk32("R9 masked comparator", cmp_value, 32'h0000_CC08);

    // High half write
    wr(2'd0, 32'h3, 4'h1);
    wr(2'd2, 32'h1234_5678, 4'hF);
    chk32("R10 high half comparator", cmp_value, 32'h0000_CC08);
    chk32("R10 high half rate", rate_value, 32'h0000_CC08);
    chk32("R6 vset cleared by high half", {31'd0, vset_armed}, 0);

    // Periodic advance across wrap
    wr(2'd0, 32'h3, 4'h1);
    wr(2'd1, 32'hFFFF_FFF0, 4'hF);
    cnt_val = 32'hFFFF_FFEE; cnt_en = 1;
    while (cnt_val != 32'hFFFF_FFF1) cyc();
    chk32("R4 fire near top", {31'd0, fire}, 1);
    chk32("R4 advance wraps", cmp_value, 32'hFFFF_FFE0);
    cnt_en = 0;

    // Write and match on the same edge
    wr(2'd0, 32'h3, 4'h1);
    cnt_val = 32'hFFFF_FFE0; cnt_en = 1;
    wr(2'd1, 32'h90, 4'hF);
    cnt_en = 0;
    chk32("R12 fire on collision", {31'd0, fire}, 1);
    chk32("R12 write wins", cmp_value, 32'h90);
    chk32("R12 rate written", rate_value, 32'h90);

    // Leaving periodic mode, lane-0 gating, unused address
    wr(2'd0, 32'h0, 4'h1);
    chk32("R7 rate zeroed", rate_value, 0);
    wr(2'd0, 32'h1, 4'h1);
    chk32("R7 rate stays zero on re-entry", rate_value, 0);
    wr(2'd0, 32'h0, 4'h0);
    chk32("R11 lane 0 masked config ignored", {31'd0, mode_periodic}, 1);
    wr(2'd3, 32'hFFFF, 4'hF);
    chk32("R11 unused address ignored", cmp_value, 32'h90);
    cyc();
    summary();
  end
endmodule